// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block drives a fixed, repeating debug pattern onto the four 8-bit data output ports of a dual-channel converter and onto its out-of-range flag, in place of sampled data. Each port has its own base byte. Every output word is either the normal form, made of the base bytes, or the inverted form, made of their bitwise complements. The out-of-range flag is set on inverted words only. The two output modes use different fixed orders of normal and inverted words.

The generator runs on the output word clock. An output-clock reset input, sampled on that clock, holds every output at zero and restarts the sequence. The enable and mode inputs are taken in while that reset is held. When the reset is released, all ports start the pattern in step on the same word. If enable or mode changes while the pattern is running, the current period finishes first, and the new setting takes effect from word 0 of the next period.

Top module: `tpg_top`

## Requirements
- R1: While rst_ni is low, and on the word after any clock edge where word_rst_i is high, qd_o, id_o, q_o, i_o and oor_o are all zero.
- R2: A normal word in demultiplexed mode (demux_i=1) puts 01h, 02h, 03h and 04h on qd_o, id_o, q_o and i_o, with oor_o=0.
- R3: An inverted word puts the bitwise complement of each active port's base byte on that port (FEh, FDh, FCh, FBh), with oor_o=1.
- R4: In demultiplexed mode the words repeat with period 5 in the order N, I, N, I, N (N normal, I inverted).
- R5: In non-demultiplexed mode (demux_i=0) the words repeat with period 10 in the order N, I, N, N, I, I, N, N, I, N. Only q_o and i_o carry the pattern (01h/02h, inverted FEh/FDh), and qd_o and id_o stay 0.
- R6: The first clock edge with word_rst_i low after a reset produces word 0 of the sequence, a normal word, on all ports together.
- R7: With the enable taken as 0, all ports and oor_o are 0 while the sequence counter keeps running.
- R8: A change of tp_en_i or demux_i without a reset takes effect after the last word of the current period, and the following word is word 0 of the new setting.
- R9: The tp_en_i and demux_i values present on the last edge of a word_rst_i pulse set the pattern that starts when the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output word clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_rst_i | input | 1 | Output-clock reset, active high, sampled on clk_i |
| tp_en_i | input | 1 | Test pattern enable |
| demux_i | input | 1 | 1: demultiplexed four-port mode, 0: two-port mode |
| qd_o | output | 8 | Delayed Q port |
| id_o | output | 8 | Delayed I port |
| q_o | output | 8 | Q port |
| i_o | output | 8 | I port |
| oor_o | output | 1 | Out-of-range flag, high on inverted words |

## Verification
The bench checks the sequence in both modes, with the enable on and off, over three or more periods. If a phase table were wrong, or a period ran one word long, the mismatch would show within one period. It changes the mode in the middle of a period and checks that the words already started still finish in the old order. A design that switched at once would show the new mode's word 2 or 3 where the old tail belongs. It also releases the reset and checks the very first word. A design that let the counter advance during the reset, or that emitted an idle word after release, would start off phase with the other ports.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int unsigned DMX_LEN = 5;
  localparam int unsigned ND_LEN  = 10;
  // bit k set: word k is inverted
  localparam logic [DMX_LEN-1:0] DMX_INV = 5'b01010;
  localparam logic [ND_LEN-1:0]  ND_INV  = 10'b01_0011_0010;
  localparam int unsigned IDX_W = $clog2(ND_LEN);

  typedef struct packed {
    logic en;
    logic dm;
  } tpg_cfg_t;
endpackage

// File: rtl/tpg_seq.sv
module tpg_seq
  import tpg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_rst_i,
  input  logic             en_i,
  input  logic             dm_i,
  output tpg_cfg_t         cfg_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] last;
  assign last = cfg_o.dm ? IDX_W'(DMX_LEN - 1) : IDX_W'(ND_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      idx_o <= '0;
    end else if (word_rst_i) begin
      cfg_o <= '{en: en_i, dm: dm_i};
      idx_o <= '0;
    end else if (idx_o == last) begin
      cfg_o <= '{en: en_i, dm: dm_i};
      idx_o <= '0;
    end else begin
      idx_o <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/tpg_phase.sv
module tpg_phase
  import tpg_pkg::*;
(
  input  logic             dm_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             inv_o
);
  always_comb begin
    inv_o = 1'b0;
    if (dm_i) begin
      if (int'(idx_i) < DMX_LEN) inv_o = DMX_INV[idx_i[$clog2(DMX_LEN)-1:0]];
    end else begin
      if (int'(idx_i) < ND_LEN) inv_o = ND_INV[idx_i];
    end
  end
endmodule

// File: rtl/tpg_port.sv
module tpg_port #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] BASE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         drive_i,
  input  logic         inv_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (!drive_i) data_o <= '0;
    else              data_o <= inv_i ? ~BASE : BASE;
  end
endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] BASE_QD = 8'h01,
  parameter logic [W-1:0] BASE_ID = 8'h02,
  parameter logic [W-1:0] BASE_Q  = 8'h03,
  parameter logic [W-1:0] BASE_I  = 8'h04
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         word_rst_i,
  input  logic         tp_en_i,
  input  logic         demux_i,
  output logic [W-1:0] qd_o,
  output logic [W-1:0] id_o,
  output logic [W-1:0] q_o,
  output logic [W-1:0] i_o,
  output logic         oor_o
);
  import tpg_pkg::*;

  localparam int unsigned NPORT = 4;
  // two-port mode maps Q/I patterns onto the base bytes 01h/02h
  localparam logic [NPORT-1:0][W-1:0] BASE_DM = {BASE_I, BASE_Q, BASE_ID, BASE_QD};
  localparam logic [NPORT-1:0][W-1:0] BASE_ND = {BASE_ID, BASE_QD, {W{1'b0}}, {W{1'b0}}};

  tpg_cfg_t         cfg;
  logic [IDX_W-1:0] idx;
  logic             inv;
  logic             live;
  logic [NPORT-1:0][W-1:0] dm_data, nd_data;

  tpg_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_rst_i(word_rst_i),
    .en_i      (tp_en_i),
    .dm_i      (demux_i),
    .cfg_o     (cfg),
    .idx_o     (idx)
  );

  tpg_phase u_phase (
    .dm_i (cfg.dm),
    .idx_i(idx),
    .inv_o(inv)
  );

  assign live = !word_rst_i && cfg.en;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    tpg_port #(.W(W), .BASE(BASE_DM[p])) u_dm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .drive_i(live && cfg.dm),
      .inv_i  (inv),
      .data_o (dm_data[p])
    );
    if (p >= 2) begin : g_nd
      tpg_port #(.W(W), .BASE(BASE_ND[p])) u_nd (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .drive_i(live && !cfg.dm),
        .inv_i  (inv),
        .data_o (nd_data[p])
      );
    end else begin : g_nd_off
      assign nd_data[p] = '0;
    end
  end

  tpg_port #(.W(1), .BASE(1'b0)) u_oor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drive_i(live),
    .inv_i  (inv),
    .data_o (oor_o)
  );

  assign qd_o = dm_data[0] | nd_data[0];
  assign id_o = dm_data[1] | nd_data[1];
  assign q_o  = dm_data[2] | nd_data[2];
  assign i_o  = dm_data[3] | nd_data[3];
endmodule

// File: rtl/tpg_top_chk.sv
module tpg_top_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         word_rst_i,
  input logic [W-1:0] qd_o,
  input logic [W-1:0] id_o,
  input logic [W-1:0] q_o,
  input logic [W-1:0] i_o,
  input logic         oor_o
);
  p_quiet_after_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_rst_i |=> (qd_o == '0 && id_o == '0 && q_o == '0 && i_o == '0 && !oor_o));

  p_oor_on_inverted_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o != '0 && q_o[W-1]) |-> oor_o);

  p_oor_needs_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_o |-> (q_o != '0 && i_o != '0));

  p_no_triple_inv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oor_o && $past(oor_o)) |=> !oor_o);

  p_twoport_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qd_o == '0) |-> (id_o == '0));

  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0 && !oor_o));
endmodule

bind tpg_top tpg_top_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .word_rst_i(word_rst_i),
  .qd_o      (qd_o),
  .id_o      (id_o),
  .q_o       (q_o),
  .i_o       (i_o),
  .oor_o     (oor_o)
);

// File: tb/tpg_top_bench.sv
module tpg_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, en = 1'b0, dm = 1'b0;
  logic [7:0] qd, id, q, i;
  logic oor;
  int checks = 0, fails = 0;
  bit done = 0;

  // bench-side model state
  int  m_idx = 0;
  bit  m_en = 0, m_dm = 0;

  always #10 clk = ~clk;

  tpg_top u_tpg_top (
    .clk_i(clk), .rst_ni(rst_n), .word_rst_i(wr), .tp_en_i(en), .demux_i(dm),
    .qd_o(qd), .id_o(id), .q_o(q), .i_o(i), .oor_o(oor)
  );

  function automatic bit inv_at(bit d, int k);
    if (d) return (k == 1 || k == 3);
    return (k == 1 || k == 4 || k == 5 || k == 8);
  endfunction

  task automatic cmp(string rq, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // one word: inputs set now (at negedge), check after the next edge
  task automatic word(bit w, bit e, bit d, string rq);
    logic [7:0] eqd, eid, eq, ei;
    bit eo, iv;
    wr = w; en = e; dm = d;
    @(posedge clk);
    eqd = 0; eid = 0; eq = 0; ei = 0; eo = 0;
    if (w) begin
      m_en = e; m_dm = d; m_idx = 0;
    end else begin
      iv = inv_at(m_dm, m_idx);
      if (m_en) begin
        eo = iv;
        if (m_dm) begin
          eqd = 8'h01; eid = 8'h02; eq = 8'h03; ei = 8'h04;
        end else begin
          eq = 8'h01; ei = 8'h02;
        end
        if (iv) begin
          eq = ~eq; ei = ~ei;
          if (m_dm) begin eqd = ~eqd; eid = ~eid; end
        end
      end
      if (m_idx == (m_dm ? 4 : 9)) begin
        m_idx = 0; m_en = e; m_dm = d;
      end else m_idx++;
    end
    @(negedge clk);
    cmp(rq, {qd, id, q, i, 7'b0, oor}, {eqd, eid, eq, ei, 7'b0, eo});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    cmp("R1 async reset", {qd, id, q, i, 7'b0, oor}, 40'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // sweep both modes, enabled and disabled, via word reset
    for (int md = 0; md < 2; md++) begin
      for (int ee = 0; ee < 2; ee++) begin
        word(1, ee[0], md[0], "R1 R9 word reset");
        word(1, ee[0], md[0], "R1 word reset held");
        word(0, ~ee[0], ~md[0], "R6 R9 first word");
        for (int k = 0; k < 31; k++)
          word(0, ee[0], md[0], md ? "R2 R3 R4 R7 demux" : "R3 R5 R7 two-port");
      end
    end
    // mid-period changes without reset
    word(1, 1, 1, "R1 reset");
    word(0, 1, 1, "R6");
    word(0, 1, 1, "R4");
    for (int k = 0; k < 14; k++) word(0, 1, 0, "R8 demux->two-port");
    for (int k = 0; k < 13; k++) word(0, 1, 1, "R8 two-port->demux");
    for (int k = 0; k < 7; k++)  word(0, 0, 1, "R8 R7 disable");
    for (int k = 0; k < 12; k++) word(0, 1, 0, "R8 enable two-port");
    // reset in the middle of a period
    word(1, 1, 0, "R1 mid reset");
    for (int k = 0; k < 12; k++) word(0, 1, 0, "R6 R5 restart");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule